// File: doc/BRIEF.md
# Region-Split Virtual Address Translator

This block turns a 32-bit virtual address into a 30-bit physical address through 512-byte pages. Two bits at the top of the address pick one of three regions. Two application regions cover the lower half of the space: a program region and a stack/control region. The upper half is a shared system region. Each region has its own single-level page table, described by a base and a length. The system table base is a physical address. The two application table bases are system virtual addresses. So the entry for an application page has to be located through the system table before the entry itself can be read.

A requester offers an address with `reqValid` while `busy` is low. The block then checks the page number against the region's length. It fetches one entry for a system page and two for an application page, on a simple request/acknowledge memory read port. It returns a single-cycle response carrying either the physical address or a fault code and the level at which the fault arose. Only one translation is in flight at a time.

Top module: `vaddr_xlate`

## Requirements
- R1: Address bits 31:30 pick the region: 00 the program region, 01 the stack region, 10 or 11 the system region. The page number is bits 29:9 and the byte offset is bits 8:0.
- R2: A system-region page is translated with one read at `sysBase + 4*page`. When that entry is valid (bit 31 set), the result is `{entry[20:0], offset}` with fault code 00.
- R3: An application page first forms the entry's system virtual address `E = base + 4*page`. It reads the system entry at `sysBase + 4*E[29:9]`, then reads the page's entry at `{systemEntry[20:0], E[8:0]}`. That makes exactly two reads. The result is formed as in R2.
- R4: A page number equal to or above its region's length gives fault code 01 with level 0, and the block makes no memory read.
- R5: For an application page, an entry address E with bit 31 clear (outside system space) gives fault code 01 with level 1 and no memory read. So does an E whose system page E[29:9] is at or above `sysLen`.
- R6: An entry with bit 31 clear gives fault code 10. The level is 1 if it was the system entry fetched to locate an application entry: the translation then stops after that one read. The level is 0 if it was the entry of the requested page itself.
- R7: Every response that carries a nonzero fault code reports physical address 0. Fault code 11 never appears.
- R8: `busy` rises in the cycle after a request is accepted and stays high through the response cycle. `rspValid` is high for exactly one cycle, and `busy` is low in the next cycle. Requests offered while `busy` is high are ignored and produce no response.
- R9: A memory read holds `memReq` high with a stable `memAddr` until `memAck`. Entry bits 30:21 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Translation request, taken when `busy` is low |
| reqVaddr | input | 32 | Virtual address to translate |
| busy | output | 1 | A translation is in progress |
| rspValid | output | 1 | One-cycle response strobe |
| rspPaddr | output | 30 | Physical address (0 on fault) |
| rspFault | output | 2 | 00 ok, 01 length violation, 10 entry not valid |
| rspLevel | output | 1 | 1 if the fault arose locating an application entry, else 0 |
| memReq | output | 1 | Entry read request |
| memAddr | output | 30 | Physical address of the entry |
| memAck | input | 1 | Read data valid; completes the read |
| memData | input | 32 | Entry read data |
| sysBase | input | 30 | Physical base of the system table |
| sysLen | input | 21 | System table length in entries |
| p0Base | input | 32 | System virtual base of the program table |
| p0Len | input | 21 | Program table length |
| p1Base | input | 32 | System virtual base of the stack table |
| p1Len | input | 21 | Stack table length |

## Verification
The hardest outcomes to reach from the ports are the level-1 faults. These need an application page whose entry address falls on an invalid system entry, or past the end of the system table, or outside system space. Random page numbers over a hashed memory image rarely produce them. The bench therefore forces one system entry invalid and moves the application table bases next to the system table's end and into application space. It also uses random addresses spread across both sides of each length boundary, with random read latencies.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic [1:0] {REG_P0 = 2'b00, REG_P1 = 2'b01, REG_S = 2'b10} region_e;
  typedef enum logic [1:0] {FLT_NONE = 2'b00, FLT_LEN = 2'b01, FLT_INV = 2'b10} fault_e;
  typedef struct packed {
    logic latchReq;   // capture request, clear result
    logic loadSysPte; // keep frame of the system entry
    logic loadPa;     // build the final physical address
    logic fetchSys;   // memory address selects the nested system entry
  } strobes_t;
endpackage

// File: rtl/xlate_dp.sv
module xlate_dp
  import xlate_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 30,
  parameter int OFF_W = 9,
  parameter int PTE_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic [PA_W-1:0]   sysBase,
  input  logic [VA_W-3-OFF_W:0] sysLen,
  input  logic [VA_W-1:0]   p0Base,
  input  logic [VA_W-3-OFF_W:0] p0Len,
  input  logic [VA_W-1:0]   p1Base,
  input  logic [VA_W-3-OFF_W:0] p1Len,
  input  logic [PTE_W-1:0]  memData,
  output logic [PA_W-1:0]   memAddr,
  output region_e           region,
  output logic              lenFault,
  output logic              nestLenFault,
  output logic              pteValid,
  output logic [PA_W-1:0]   rspPaddr
);
  localparam int VPN_W = VA_W - 2 - OFF_W;
  localparam int PFN_W = PA_W - OFF_W;

  logic [VA_W-1:0]  vaReg;
  logic [PFN_W-1:0] sysPfnReg;
  logic [VPN_W-1:0] vpn, lenSel, tblIdx;
  logic [VA_W-1:0]  baseSel, pteVa;
  logic [PA_W-1:0]  sysPteAddr;
  logic             unusedBits;

  always_comb begin
    region = vaReg[VA_W-1] ? REG_S : (vaReg[VA_W-2] ? REG_P1 : REG_P0);
    vpn    = vaReg[VA_W-3:OFF_W];
    case (region)
      REG_P0:  begin lenSel = p0Len;  baseSel = p0Base; end
      REG_P1:  begin lenSel = p1Len;  baseSel = p1Base; end
      default: begin lenSel = sysLen; baseSel = '0;     end
    endcase
    pteVa        = baseSel + VA_W'({vpn, 2'b00});
    lenFault     = (vpn >= lenSel);
    nestLenFault = !pteVa[VA_W-1] || (pteVa[VA_W-3:OFF_W] >= sysLen);
    tblIdx       = (region == REG_S) ? vpn : pteVa[VA_W-3:OFF_W];
    sysPteAddr   = sysBase + PA_W'({tblIdx, 2'b00});
    memAddr      = ((region == REG_S) || stb.fetchSys) ? sysPteAddr
                                                       : {sysPfnReg, pteVa[OFF_W-1:0]};
    pteValid     = memData[PTE_W-1];
  end

  assign unusedBits = ^{pteVa[VA_W-2], memData[PTE_W-2:PFN_W]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaReg     <= '0;
      sysPfnReg <= '0;
      rspPaddr  <= '0;
    end else begin
      if (stb.latchReq) begin
        vaReg    <= reqVaddr;
        rspPaddr <= '0;
      end
      if (stb.loadSysPte) sysPfnReg <= memData[PFN_W-1:0];
      if (stb.loadPa)     rspPaddr  <= {memData[PFN_W-1:0], vaReg[OFF_W-1:0]};
    end
  end

  // R3: the nested system lookup only happens for application regions
  a_r3_nest_app_only: assert property (@(posedge clk) disable iff (!rstN)
    stb.fetchSys |-> (region != REG_S));
  // R2: the byte offset of the request reaches the result unchanged
  a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadPa |=> (rspPaddr[OFF_W-1:0] == vaReg[OFF_W-1:0]));
endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  region_e  region,
  input  logic     lenFault,
  input  logic     nestLenFault,
  input  logic     pteValid,
  input  logic     memAck,
  output strobes_t stb,
  output logic     memReq,
  output logic     busy,
  output logic     rspValid,
  output logic [1:0] rspFault,
  output logic     rspLevel
);
  typedef enum logic [2:0] {ST_IDLE, ST_CHECK, ST_FSYS, ST_FFIN, ST_RESP} state_e;
  state_e state, stateNxt;
  fault_e faultReg, faultNxt;
  logic   levelNxt;

  always_comb begin
    stateNxt = state;
    faultNxt = faultReg;
    levelNxt = rspLevel;
    stb      = '0;
    stb.fetchSys = (state == ST_FSYS);
    case (state)
      ST_IDLE: if (reqValid) begin
        stb.latchReq = 1'b1;
        faultNxt = FLT_NONE;
        levelNxt = 1'b0;
        stateNxt = ST_CHECK;
      end
      ST_CHECK: begin
        if (lenFault) begin
          faultNxt = FLT_LEN; stateNxt = ST_RESP;
        end else if (region == REG_S) begin
          stateNxt = ST_FFIN;
        end else if (nestLenFault) begin
          faultNxt = FLT_LEN; levelNxt = 1'b1; stateNxt = ST_RESP;
        end else begin
          stateNxt = ST_FSYS;
        end
      end
      ST_FSYS: if (memAck) begin
        if (!pteValid) begin
          faultNxt = FLT_INV; levelNxt = 1'b1; stateNxt = ST_RESP;
        end else begin
          stb.loadSysPte = 1'b1; stateNxt = ST_FFIN;
        end
      end
      ST_FFIN: if (memAck) begin
        if (!pteValid) faultNxt = FLT_INV;
        else           stb.loadPa = 1'b1;
        stateNxt = ST_RESP;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      faultReg <= FLT_NONE;
      rspLevel <= 1'b0;
    end else begin
      state    <= stateNxt;
      faultReg <= faultNxt;
      rspLevel <= levelNxt;
    end
  end

  assign busy     = (state != ST_IDLE);
  assign rspValid = (state == ST_RESP);
  assign memReq   = (state == ST_FSYS) || (state == ST_FFIN);
  assign rspFault = faultReg;

  // R8: a taken request raises busy next cycle
  a_r8_accept_busy: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> busy);
  // R8: single-cycle response followed by idle
  a_r8_rsp_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (!rspValid && !busy));
  // R7: code 11 is never reported
  a_r7_no_code3: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspFault != 2'b11));
  // R4: a length fault on the request itself never follows a read
  a_r4_len_no_read: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault == FLT_LEN) |-> $past(state == ST_CHECK));
endmodule

// File: rtl/vaddr_xlate.sv
module vaddr_xlate
  import xlate_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 30,
  parameter int OFF_W = 9,
  parameter int PTE_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [VA_W-1:0]   reqVaddr,
  output logic              busy,
  output logic              rspValid,
  output logic [PA_W-1:0]   rspPaddr,
  output logic [1:0]        rspFault,
  output logic              rspLevel,
  output logic              memReq,
  output logic [PA_W-1:0]   memAddr,
  input  logic              memAck,
  input  logic [PTE_W-1:0]  memData,
  input  logic [PA_W-1:0]   sysBase,
  input  logic [VA_W-3-OFF_W:0] sysLen,
  input  logic [VA_W-1:0]   p0Base,
  input  logic [VA_W-3-OFF_W:0] p0Len,
  input  logic [VA_W-1:0]   p1Base,
  input  logic [VA_W-3-OFF_W:0] p1Len
);
  strobes_t stb;
  region_e  region;
  logic     lenFault, nestLenFault, pteValid;

  xlate_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .region(region),
    .lenFault(lenFault), .nestLenFault(nestLenFault), .pteValid(pteValid),
    .memAck(memAck), .stb(stb), .memReq(memReq), .busy(busy),
    .rspValid(rspValid), .rspFault(rspFault), .rspLevel(rspLevel)
  );

  xlate_dp #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .PTE_W(PTE_W)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqVaddr(reqVaddr),
    .sysBase(sysBase), .sysLen(sysLen), .p0Base(p0Base), .p0Len(p0Len),
    .p1Base(p1Base), .p1Len(p1Len), .memData(memData), .memAddr(memAddr),
    .region(region), .lenFault(lenFault), .nestLenFault(nestLenFault),
    .pteValid(pteValid), .rspPaddr(rspPaddr)
  );

  // R9: a pending read keeps its request and address
  a_r9_read_held: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr)));
  // R7: faulted responses carry a zero address
  a_r7_fault_zero_pa: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault != 2'b00) |-> (rspPaddr == '0));
endmodule

// File: tb/test_vaddr_xlate.sv
module test_vaddr_xlate;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic        busy, rspValid, rspLevel, memReq;
  logic [29:0] rspPaddr, memAddr;
  logic [1:0]  rspFault;
  logic        memAck = 1'b0;
  logic [31:0] memData = '0;
  logic [29:0] sysBase = 30'h0200_0000;
  logic [20:0] sysLen = 21'd200;
  logic [31:0] p0Base = 32'h8000_0000;
  logic [20:0] p0Len = 21'd300;
  logic [31:0] p1Base = 32'h8000_4000;
  logic [20:0] p1Len = 21'd300;

  int checks = 0;
  int fails = 0;
  int fetchCnt = 0;
  int rspCnt = 0;
  logic [31:0] ovr [logic [29:0]];

  always #10 clk = ~clk;

  vaddr_xlate i_vaddr_xlate (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr),
    .busy(busy), .rspValid(rspValid), .rspPaddr(rspPaddr), .rspFault(rspFault),
    .rspLevel(rspLevel), .memReq(memReq), .memAddr(memAddr), .memAck(memAck),
    .memData(memData), .sysBase(sysBase), .sysLen(sysLen), .p0Base(p0Base),
    .p0Len(p0Len), .p1Base(p1Base), .p1Len(p1Len)
  );

  function automatic logic [31:0] memWord(logic [29:0] a);
    logic [31:0] h;
    if (ovr.exists(a)) return ovr[a];
    h = {2'b00, a} * 32'h9E37_79B1;
    h = h ^ (h >> 15);
    return {(h[2:0] != 3'd0), h[30:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // expected result from the requirements (R1..R6)
  task automatic refXlate(input logic [31:0] va, output logic [29:0] pa,
                          output logic [1:0] flt, output logic lvl, output int nf);
    logic [20:0] vpn, len;
    logic [31:0] eva, w, sw;
    vpn = va[29:9];
    pa = '0; flt = 2'b00; lvl = 1'b0; nf = 0;
    len = va[31] ? sysLen : (va[30] ? p1Len : p0Len);
    if (vpn >= len) begin flt = 2'b01; return; end
    if (va[31]) begin
      w = memWord(sysBase + {7'd0, vpn, 2'b00}); nf = 1;
      if (w[31]) pa = {w[20:0], va[8:0]}; else flt = 2'b10;
      return;
    end
    eva = (va[30] ? p1Base : p0Base) + {9'd0, vpn, 2'b00};
    if (!eva[31] || eva[29:9] >= sysLen) begin flt = 2'b01; lvl = 1'b1; return; end
    sw = memWord(sysBase + {7'd0, eva[29:9], 2'b00}); nf = 1;
    if (!sw[31]) begin flt = 2'b10; lvl = 1'b1; return; end
    w = memWord({sw[20:0], eva[8:0]}); nf = 2;
    if (w[31]) pa = {w[20:0], va[8:0]}; else flt = 2'b10;
  endtask

  // memory responder with random latency
  initial begin
    int dly = 0;
    forever begin
      @(negedge clk);
      if (memAck) memAck = 1'b0;
      else if (rstN && memReq) begin
        if (dly == 0) begin
          memAck = 1'b1;
          memData = memWord(memAddr);
          fetchCnt++;
          dly = $urandom_range(0, 2);
        end else dly--;
      end
    end
  end

  initial begin
    @(posedge rstN);
    forever begin
      @(negedge clk);
      if (rspValid) rspCnt++;
    end
  end

  task automatic doXlate(input logic [31:0] va, input string req, input bit busyPoke);
    logic [29:0] ePa; logic [1:0] eFlt; logic eLvl; int eNf;
    refXlate(va, ePa, eFlt, eLvl, eNf);
    @(negedge clk);
    while (busy) @(negedge clk);
    reqValid = 1'b1; reqVaddr = va; fetchCnt = 0;
    @(negedge clk);
    chk(busy == 1'b1, "R8", "busy after accept", {31'd0, busy}, 32'd1);
    if (busyPoke) begin
      reqVaddr = ~va;   // must be ignored while busy
      @(negedge clk);
    end
    reqValid = 1'b0;
    while (!rspValid) @(negedge clk);
    chk(rspPaddr == ePa, req, "paddr", {2'b0, rspPaddr}, {2'b0, ePa});
    chk(rspFault == eFlt, req, "fault", {30'd0, rspFault}, {30'd0, eFlt});
    chk(rspLevel == eLvl, req, "level", {31'd0, rspLevel}, {31'd0, eLvl});
    chk(fetchCnt == eNf, req, "reads", fetchCnt, eNf);
    @(negedge clk);
    chk(!busy && !rspValid, "R8", "idle after response", {30'd0, busy, rspValid}, 32'd0);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++; checks++;
        $display("FAIL watchdog: actual %0d expected below 150000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    chk(!busy && !rspValid && !memReq, "R8", "reset state",
        {29'd0, busy, rspValid, memReq}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 system region, boundaries of sysLen (R4)
    doXlate({1'b1, 1'b0, 21'd0, 9'h1A5}, "R2", 1'b0);
    doXlate({1'b1, 1'b1, 21'd199, 9'h0FF}, "R2", 1'b0);
    doXlate({1'b1, 1'b0, 21'd200, 9'h000}, "R4", 1'b0);
    // R1/R3 program and stack regions, boundaries of their lengths (R4)
    doXlate({2'b00, 21'd299, 9'h033}, "R3", 1'b0);
    doXlate({2'b00, 21'd300, 9'h033}, "R4", 1'b0);
    doXlate({2'b01, 21'd299, 9'h1FF}, "R1", 1'b0);
    doXlate({2'b01, 21'd300, 9'h1FF}, "R4", 1'b0);
    // R8: a request offered while busy is ignored
    rspCnt = 0;
    doXlate({2'b01, 21'd17, 9'h055}, "R8", 1'b1);
    repeat (8) @(negedge clk);
    chk(rspCnt == 1, "R8", "single response", rspCnt, 1);
    // R9: entry bits 30:21 are ignored
    ovr[sysBase + 30'd32] = {1'b1, 10'h3FF, 21'h0ABCD};
    doXlate({1'b1, 1'b0, 21'd8, 9'h123}, "R9", 1'b0);
    chk(rspPaddr == {21'h0ABCD, 9'h123}, "R9", "paddr fixed", {2'b0, rspPaddr},
        {2'b0, 21'h0ABCD, 9'h123});
    // R6 level 0: final entry invalid
    ovr[sysBase + 30'd28] = 32'h7FFF_FFFF;
    doXlate({1'b1, 1'b0, 21'd7, 9'h000}, "R6", 1'b0);
    chk(rspFault == 2'b10 && rspLevel == 1'b0, "R6", "final invalid",
        {29'd0, rspFault, rspLevel}, 32'd4);
    // R6 level 1: system entry locating program pages 128..255 invalid
    ovr[sysBase + 30'd4] = 32'h0000_0000;
    doXlate({2'b00, 21'd130, 9'h010}, "R6", 1'b0);
    chk(rspFault == 2'b10 && rspLevel == 1'b1 && fetchCnt == 1, "R6", "nested invalid",
        {29'd0, rspFault, rspLevel}, 32'd5);
    // R5: entry address beyond the system table, then outside system space
    p0Base = 32'h8001_8E00;
    doXlate({2'b00, 21'd5, 9'h010}, "R5", 1'b0);
    doXlate({2'b00, 21'd130, 9'h010}, "R5", 1'b0);
    chk(rspFault == 2'b01 && rspLevel == 1'b1 && fetchCnt == 0, "R5", "nested length",
        {29'd0, rspFault, rspLevel}, 32'd3);
    p1Base = 32'h0000_1000;
    doXlate({2'b01, 21'd3, 9'h010}, "R5", 1'b0);
    chk(rspFault == 2'b01 && rspLevel == 1'b1, "R5", "outside system space",
        {29'd0, rspFault, rspLevel}, 32'd3);
    p0Base = 32'h8000_0000;
    p1Base = 32'h8000_4000;

    // random mix (R1, R2, R3, R7)
    for (int i = 0; i < 400; i++) begin
      logic [31:0] va;
      va = $urandom;
      va[29:9] = (va[31]) ? 21'($urandom_range(0, 230)) : 21'($urandom_range(0, 340));
      doXlate(va, "R7", 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule